// File: doc/BRIEF.md
# Lock-After-First-Write Watchdog Timer

A watchdog that a host sets up through one 32-bit register. The first write after reset configures the timer and starts it in the same step. That write sets a 12-bit reload count, a prescale select, a run-enable and a 2-bit field that chooses the timeout action. From then on the same register only acts as a retrigger port. Any later write reloads the down-counter from the reload count that the first write stored, and the data written has no effect. The period therefore cannot change until the next reset.

The counter steps on a clock enable at half the bus clock rate. When the prescale select is set, it steps only on every PRE_DIV-th half-rate enable instead. A countdown step taken while the counter already holds zero is an expiry. The block then raises either an interrupt request or a reset request, as the action field selects. That request stays high until reset. A read returns the locked setup in bits 15:12 and the live count in bits 11:0.

Top module: `lwd_top`

## Requirements
- R1: After reset, rd_data reads 0 and both irq_o and rst_req_o are low.
- R2: The first write after reset stores the setup from wr_data. A read then shows wr_data[15:14] (action), wr_data[13] (enable) and wr_data[12] (prescale) in bits 15:12, and the reload count wr_data[11:0] in bits 11:0.
- R3: Writes after the first never change rd_data[15:12], whatever data they carry.
- R4: A write after the first, made before any timeout, sets the count to the stored reload value on the edge that captures it.
- R5: With prescale 0 and enable 1, the count goes down by one every second clock edge. It reads N-k after edge 2k, where edge 0 captures the start or retrigger write.
- R6: With prescale 1, the count goes down once every 2*PRE_DIV clock edges, the first step coming on edge 2*PRE_DIV (PRE_DIV defaults to 16384).
- R7: A countdown step at count 0 is an expiry. Without prescale and without a retrigger, it happens on edge 2(N+1), and the count stays 0.
- R8: On expiry, irq_o goes high if the action field is 2 (binary 10). For any other action value, rst_req_o goes high instead.
- R9: Once high, the timeout output stays high until reset, and writes no longer change the count.
- R10: If the enable bit of the first write is 0, the setup still locks but the count never moves and no timeout occurs.
- R11: A reload value of 0 expires on edge 2 after the start or retrigger, with no timeout on edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one per cycle held |
| wr_data | input | 32 | Write data; bits 31:16 unused |
| rd_data | output | 32 | Locked setup in 15:12, live count in 11:0 |
| irq_o | output | 1 | Sticky timeout interrupt request (action 2) |
| rst_req_o | output | 1 | Sticky timeout reset request (other actions) |

## Verification
The bench samples the count on both sides of each step and of the expiry edge. A design off by one in the half-rate phase, or one that expires on reaching zero rather than on the step after it, fails on those samples. A retrigger whose data differs from the stored setup catches a design that overwrites the setup. Retriggering after expiry exposes a timeout that is not sticky or a counter that can restart. A first write with enable clear, and a first write with a reload of zero, expose designs that count while disabled or that miss the expiry at count zero.

// File: rtl/lwd_pkg.sv
// Package: field layout of the watchdog setup register and shared constants.
// Assumes the setup occupies the low 16 bits of the bus word.
package lwd_pkg;
    localparam int RELOAD_W = 12;
    localparam int SETUP_W  = 16;

    // Action field code that selects the interrupt request.
    localparam logic [1:0] ACT_IRQ = 2'b10;

    // Setup word: packed MSB first so bit positions match the register.
    typedef struct packed {
        logic [1:0]          action;    // 15:14
        logic                enable;    // 13
        logic                prescale;  // 12
        logic [RELOAD_W-1:0] reload;    // 11:0
    } lwd_setup_t;
endpackage

// File: rtl/lwd_setup_lock.sv
// Module: holds the setup captured by the first write after reset and
// turns every write (before expiry) into a counter load request.
// Assumes: wr_en is a single-cycle-per-write strobe in the clk domain.
module lwd_setup_lock
    import lwd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  lwd_setup_t          wr_setup,
    input  logic                expired,
    output lwd_setup_t          setup_q,
    output logic                locked_q,
    output logic                load,
    output logic [RELOAD_W-1:0] load_val
);
    // Load request: the first write starts, later writes retrigger until expiry.
    always_comb begin
        load     = wr_en && (!locked_q || !expired);
        load_val = locked_q ? setup_q.reload : wr_setup.reload;
    end

    // Capture the setup once and keep it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q  <= '0;
            locked_q <= 1'b0;
        end else if (wr_en && !locked_q) begin
            setup_q  <= wr_setup;
            locked_q <= 1'b1;
        end
    end

    // R3: once locked, setup and lock do not change before reset.
    a_r3_setup_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> (locked_q && $stable(setup_q)));

    // R2: first write is captured into the setup.
    a_r2_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !locked_q) |=> (locked_q && setup_q == $past(wr_setup)));
endmodule

// File: rtl/lwd_tick_gen.sv
// Module: produces the single-cycle countdown enable. A half-rate enable
// is formed first, and an optional divide-by-PRE_DIV stage follows.
// Assumes: restart realigns both stages so the timing is fixed from a load.
module lwd_tick_gen #(
    parameter int PRE_DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic prescale,
    output logic tick
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic half_q;
    logic half_tick;
    logic pre_tick;

    // Toggle at half rate while running; restart puts the phase at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) half_q <= 1'b0;
        else if (run)          half_q <= ~half_q;
    end

    assign half_tick = run && half_q;

    // Prescale stage: bypassed when the division is 1.
    if (PRE_DIV > 1) begin : g_pre
        localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
        logic [PRE_W-1:0] pre_cnt_q;

        // Count half-rate enables, wrapping at the division.
        always_ff @(posedge clk) begin
            if (!rst_n || restart)       pre_cnt_q <= '0;
            else if (half_tick)          pre_cnt_q <= (pre_cnt_q == PRE_LAST) ? '0 : pre_cnt_q + 1'b1;
        end

        assign pre_tick = half_tick && (pre_cnt_q == PRE_LAST);
    end else begin : g_nopre
        assign pre_tick = half_tick;
    end

    // Select the countdown enable.
    assign tick = prescale ? pre_tick : half_tick;

    // R5: the enable is never high on two edges in a row.
    a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/lwd_counter.sv
// Module: down-counter with sticky expiry flag.
// Assumes: tick is only high while counting is allowed and before expiry.
module lwd_counter
    import lwd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RELOAD_W-1:0] load_val,
    input  logic                tick,
    output logic [RELOAD_W-1:0] count_q,
    output logic                expired_q
);
    // Load from the reload value, or step down on a tick while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count_q <= '0;
        else if (load)                    count_q <= load_val;
        else if (tick && count_q != '0)   count_q <= count_q - 1'b1;
    end

    // Set the expiry flag on a step taken at zero; hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  expired_q <= 1'b0;
        else if (tick && count_q == '0 && !load)     expired_q <= 1'b1;
    end

    // R9: expiry is sticky.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        expired_q |=> expired_q);

    // R7: a step at zero leads to expiry.
    a_r7_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_q == '0 && !load) |=> expired_q);

    // R4: a load puts the reload value in the counter.
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(load_val)));

    // R9: after expiry the count no longer moves.
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        expired_q |=> $stable(count_q));
endmodule

// File: rtl/lwd_top.sv
// Module: watchdog top. One register: the first write sets up and starts
// the timer, every later write retriggers it. A read shows setup and count.
// Assumes: a single register, so no address decode; synchronous reset.
module lwd_top
    import lwd_pkg::*;
#(
    parameter int PRE_DIV = 16384
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq_o,
    output logic        rst_req_o
);
    lwd_setup_t          wr_setup;
    lwd_setup_t          setup_q;
    logic                locked_q;
    logic                load;
    logic [RELOAD_W-1:0] load_val;
    logic                expired_q;
    logic [RELOAD_W-1:0] count_q;
    logic                run;
    logic                tick;
    logic                unused_hi;

    assign wr_setup  = lwd_setup_t'(wr_data[SETUP_W-1:0]);
    assign unused_hi = ^wr_data[31:SETUP_W];

    lwd_setup_lock i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_setup (wr_setup),
        .expired  (expired_q),
        .setup_q  (setup_q),
        .locked_q (locked_q),
        .load     (load),
        .load_val (load_val)
    );

    // Counting is allowed only with a locked, enabled setup before expiry.
    assign run = locked_q && setup_q.enable && !expired_q;

    lwd_tick_gen #(.PRE_DIV(PRE_DIV)) i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (load),
        .run      (run),
        .prescale (setup_q.prescale),
        .tick     (tick)
    );

    lwd_counter i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (load_val),
        .tick      (tick),
        .count_q   (count_q),
        .expired_q (expired_q)
    );

    // Read mux and timeout action decode.
    always_comb begin
        rd_data   = {16'b0, setup_q.action, setup_q.enable, setup_q.prescale, count_q};
        irq_o     = expired_q && (setup_q.action == ACT_IRQ);
        rst_req_o = expired_q && (setup_q.action != ACT_IRQ);
    end

    // R10: a disabled setup never times out.
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && !setup_q.enable) |-> (!irq_o && !rst_req_o));

    // R8: only one kind of timeout request at a time.
    a_r8_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, rst_req_o}));
endmodule

// File: tb/test_lwd_top.sv
module test_lwd_top;
    localparam int CLK_PERIOD = 10;
    localparam int PDIV       = 4;
    localparam int NVEC       = 13;

    // Vector: {setup[15:0], wait edges[7:0], {irq,rst}[1:0], expected read[15:0]}
    localparam logic [41:0] VEC [NVEC] = '{
        {16'hA005, 8'd4,  2'b00, 16'hA003},  // R5
        {16'hA005, 8'd11, 2'b00, 16'hA000},  // R7 edge before expiry
        {16'hA005, 8'd12, 2'b10, 16'hA000},  // R7 R8 irq
        {16'h2002, 8'd5,  2'b00, 16'h2000},  // R7
        {16'h2002, 8'd6,  2'b01, 16'h2000},  // R8 action 0 -> reset request
        {16'hE001, 8'd4,  2'b01, 16'hE000},  // R8 action 3
        {16'hB003, 8'd7,  2'b00, 16'hB003},  // R6 before first step
        {16'hB003, 8'd8,  2'b00, 16'hB002},  // R6 first step
        {16'hB003, 8'd31, 2'b00, 16'hB000},  // R6
        {16'hB003, 8'd32, 2'b10, 16'hB000},  // R6 expiry
        {16'h8007, 8'd40, 2'b00, 16'h8007},  // R10
        {16'hA000, 8'd1,  2'b00, 16'hA000},  // R11 no expiry on edge 1
        {16'hA000, 8'd2,  2'b10, 16'hA000}   // R11 expiry on edge 2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o;
    logic        rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lwd_top #(.PRE_DIV(PDIV)) i_lwd_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write: set at a falling edge, captured on the next rising edge (edge 0).
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 read", rd_data, 32'h0);
        check("R1 outs", {30'b0, irq_o, rst_req_o}, 32'h0);

        // Table of setups and sample points
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            wr({16'hFFFF, VEC[v][41:26]});
            wait_edges(int'(VEC[v][25:18]));
            check($sformatf("R2/R5-R11 vec%0d read", v), rd_data, {16'h0, VEC[v][15:0]});
            check($sformatf("R8 vec%0d outs", v), {30'b0, irq_o, rst_req_o}, {30'b0, VEC[v][17:16]});
        end

        // Retrigger and lock behaviour
        do_reset();
        wr(32'h0000_A004);
        check("R2 setup", rd_data, 32'h0000_A004);
        wait_edges(6);
        check("R5 count", rd_data, 32'h0000_A001);
        wr(32'hFFFF_1005);
        check("R3 R4 retrigger", rd_data, 32'h0000_A004);
        wait_edges(9);
        check("R7 before expiry", {29'b0, irq_o, rst_req_o, 1'b0}, 32'h0);
        check("R4 count", rd_data, 32'h0000_A000);
        wait_edges(1);
        check("R7 R8 irq", {30'b0, irq_o, rst_req_o}, 32'h2);
        wr(32'h0000_0003);
        wait_edges(5);
        check("R9 sticky", {30'b0, irq_o, rst_req_o}, 32'h2);
        check("R9 count frozen", rd_data, 32'h0000_A000);

        // Reset then a fresh, disabled setup
        do_reset();
        check("R1 after run", {rd_data[31:2], irq_o, rst_req_o}, 32'h0);
        wr(32'h0000_1003);
        wr(32'h0000_A00F);
        wait_edges(20);
        check("R10 locked disabled", rd_data, 32'h0000_1003);
        check("R10 no timeout", {30'b0, irq_o, rst_req_o}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule